// File: doc/BRIEF.md
# Serial Absolute Position Transmitter (multi-turn plus single-turn)

This block builds one absolute position word from a revolution count and an angle within the revolution, and sends it to a reader over a synchronous serial link. The reader supplies the serial clock and the block supplies the data. The block runs on a fast internal clock, nominally 16 MHz, and brings the reader's clock in through a two-flop synchroniser. Edges are found by comparing the current synchronised sample with the previous one. Serial clocks whose half period is at least two internal cycles are supported, which covers 0.5 MHz to 4 MHz at a 16 MHz internal clock.

The revolution count is sent first and the angle second. Each part is sent most significant bit first. A strobe output shows whether the outgoing word is locked. The strobe drops for a latch window after reset and after every frame, and during that window a fresh position is taken from the parallel inputs. An input can invert the top bit of the word so that the counting direction is reversed. A build parameter selects whether each part is sent in plain binary or in Gray code.

The serial clock idles high. The first falling edge opens a frame. If the serial clock stays quiet for a set number of internal cycles, an unfinished frame is abandoned, and after a finished frame that same quiet time is needed before the block will accept a new one.

Top module: `ssi_position_tx`

## Requirements
- R1: A frame carries MT_BITS + ST_BITS bits. The falling edge that opens the frame is followed by MT_BITS + ST_BITS further falling edges. Just before each of these edges, `sdata` holds the next bit: first the revolution count from its top bit down, then the angle from its top bit down. After the last of these edges the frame is over.
- R2: When `msb_inv` is 1 at the moment the word is loaded, bit MT_BITS+ST_BITS-1 of the combined binary word ({revolution, angle}) is inverted. When it is 0, no bit is changed.
- R3: When GRAY_CODE is 1, the revolution part and the angle part are each converted separately as g = b ^ (b >> 1). The conversion is applied after the inversion of R2.
- R4: `strobe` is 0 for LATCH_CYCLES internal cycles after reset and after every frame ends or is abandoned. It is 1 at all other times, including every cycle of a frame.
- R5: `sdata` is 1 while the block is locked and waiting for a frame. It is 0 from the end of a frame until the next latch window has finished.
- R6: After the last bit of a frame, falling edges that arrive before the serial clock has been quiet for IDLE_CYCLES internal cycles do not start a frame. `sdata` stays 0 and `strobe` stays 1.
- R7: If the serial clock shows no edge for IDLE_CYCLES internal cycles in the middle of a frame, the frame is abandoned and the latch window of R4 follows. The next frame then carries a freshly loaded word.
- R8: The position inputs are captured only during a latch window, and only in cycles where `pos_valid` is 1. Changing the inputs while `strobe` is 1 does not change the frame in progress. If `pos_valid` stays 0 through a whole window, the previous position is sent again.
- R9: While reset is applied, `strobe` and `sdata` are 0 and the held position is cleared to zero. A frame read after a latch window with no valid input therefore carries the all-zero position, with the encoding of R2 and R3 applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, nominally 16 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mt_pos | input | MT_BITS | Revolution count from the multi-turn stage |
| st_pos | input | ST_BITS | Angle within the revolution from the single-turn sensor |
| pos_valid | input | 1 | Qualifies `mt_pos` and `st_pos` for capture |
| sclk | input | 1 | Serial clock from the reader, idles high, asynchronous to `clk` |
| msb_inv | input | 1 | 1 inverts the top bit of the word to reverse the counting direction |
| sdata | output | 1 | Serial data to the reader |
| strobe | output | 1 | 1 while the outgoing word is locked, 0 during a latch window |

## Verification
Complete frames are read at 0.5 MHz and at 4 MHz. At 4 MHz the synchroniser delay is close to a full serial period, so this rate shows whether the bit pointer advances on the right edge. At 0.5 MHz the rate shows whether a slow but legal reader is mistaken for a stalled one. Two instances are read together: a binary one with a 12-bit count and a Gray one with a 14-bit count. With the same position values, the two show whether the inversion lands on the top bit and whether the coding is done per part. Words with alternating bits, with all bits set and with a single top bit set show whether the ordering or the split point between the parts is wrong. Other patterns tell the short-gap rule, the mid-frame timeout and a latch window with no valid input apart from normal operation: a burst of clock edges soon after a frame, a frame cut off after a few bits, and a window in which `pos_valid` is held low.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;
  typedef enum logic [1:0] {
    ST_LATCH = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } ssi_state_e;
endpackage

// File: rtl/ssi_clk_sync.sv
module ssi_clk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic s_meta, s_sync, s_prev;

  // Serial clock idles high, so the chain resets high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b1;
      s_sync <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s_meta <= sclk_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  always_comb begin
    sclk_rise = s_sync & ~s_prev;
    sclk_fall = ~s_sync & s_prev;
  end
endmodule

// File: rtl/ssi_word_encoder.sv
module ssi_word_encoder #(
  parameter int MT_BITS   = 12,
  parameter int ST_BITS   = 12,
  parameter int GRAY_CODE = 0
) (
  input  logic [MT_BITS-1:0]         mt_in,
  input  logic [ST_BITS-1:0]         st_in,
  input  logic                       inv,
  output logic [MT_BITS+ST_BITS-1:0] word
);
  localparam int WORD_BITS = MT_BITS + ST_BITS;

  logic [WORD_BITS-1:0] bin_w;

  always_comb begin
    bin_w = {mt_in, st_in};
    bin_w[WORD_BITS-1] = bin_w[WORD_BITS-1] ^ inv;
  end

  generate
    if (GRAY_CODE != 0) begin : g_gray
      logic [MT_BITS-1:0] mt_b;
      logic [ST_BITS-1:0] st_b;
      always_comb begin
        mt_b = bin_w[WORD_BITS-1:ST_BITS];
        st_b = bin_w[ST_BITS-1:0];
        word = {mt_b ^ (mt_b >> 1), st_b ^ (st_b >> 1)};
      end
    end else begin : g_bin
      always_comb word = bin_w;
    end
  endgenerate
endmodule

// File: rtl/ssi_frame_ctrl.sv
module ssi_frame_ctrl
  import ssi_tx_pkg::*;
#(
  parameter int WORD_BITS    = 24,
  parameter int IDLE_CYCLES  = 640,
  parameter int LATCH_CYCLES = 560
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  input  logic [WORD_BITS-1:0] enc_word,
  output ssi_state_e           state,
  output logic [WORD_BITS-1:0] frame_word,
  output logic                 sdata,
  output logic                 strobe
);
  localparam int PTR_W   = $clog2(WORD_BITS);
  localparam int MAX_CYC = (IDLE_CYCLES > LATCH_CYCLES) ? IDLE_CYCLES : LATCH_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] IDLE_END  = CNT_W'(IDLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LATCH_END = CNT_W'(LATCH_CYCLES - 1);

  ssi_state_e       nxt_state;
  logic [PTR_W-1:0] ptr, nxt_ptr, bit_idx;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             load_en, ptr_en;

  // Quiet-time counter shared by SHIFT and GAP, latch timer in LATCH.
  always_comb begin
    nxt_state = state;
    nxt_ptr   = ptr;
    nxt_cnt   = cnt;
    load_en   = 1'b0;
    ptr_en    = 1'b0;
    case (state)
      ST_LATCH: begin
        if (cnt == LATCH_END) begin
          nxt_state = ST_IDLE;
          nxt_cnt   = '0;
          load_en   = 1'b1;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
      ST_IDLE: begin
        nxt_cnt = '0;
        if (sclk_fall) begin
          nxt_state = ST_SHIFT;
          nxt_ptr   = '0;
          ptr_en    = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (sclk_fall) begin
          nxt_cnt = '0;
          if (ptr == LAST_PTR) begin
            nxt_state = ST_GAP;
          end else begin
            nxt_ptr = ptr + 1'b1;
            ptr_en  = 1'b1;
          end
        end else if (sclk_rise) begin
          nxt_cnt = '0;
        end else if (cnt == IDLE_END) begin
          nxt_state = ST_LATCH;
          nxt_cnt   = '0;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
      default: begin
        if (sclk_fall || sclk_rise) begin
          nxt_cnt = '0;
        end else if (cnt == IDLE_END) begin
          nxt_state = ST_LATCH;
          nxt_cnt   = '0;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_LATCH;
      cnt        <= '0;
      ptr        <= '0;
      frame_word <= '0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
      if (ptr_en)  ptr        <= nxt_ptr;
      if (load_en) frame_word <= enc_word;
    end
  end

  always_comb begin
    bit_idx = LAST_PTR - ptr;
    strobe  = (state != ST_LATCH);
    case (state)
      ST_IDLE:  sdata = 1'b1;
      ST_SHIFT: sdata = frame_word[bit_idx];
      default:  sdata = 1'b0;
    endcase
  end
endmodule

// File: rtl/ssi_position_tx.sv
module ssi_position_tx
  import ssi_tx_pkg::*;
#(
  parameter int MT_BITS      = 12,
  parameter int ST_BITS      = 12,
  parameter int GRAY_CODE    = 0,
  parameter int IDLE_CYCLES  = 640,
  parameter int LATCH_CYCLES = 560
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MT_BITS-1:0] mt_pos,
  input  logic [ST_BITS-1:0] st_pos,
  input  logic               pos_valid,
  input  logic               sclk,
  input  logic               msb_inv,
  output logic               sdata,
  output logic               strobe
);
  localparam int WORD_BITS = MT_BITS + ST_BITS;

  logic                 rst_meta, rst_n_int;
  logic                 sclk_rise, sclk_fall;
  logic                 cap_en;
  logic [MT_BITS-1:0]   cap_mt;
  logic [ST_BITS-1:0]   cap_st;
  logic [WORD_BITS-1:0] enc_word, frame_word;
  ssi_state_e           state;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  always_comb cap_en = (state == ST_LATCH) && pos_valid;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cap_mt <= '0;
      cap_st <= '0;
    end else if (cap_en) begin
      cap_mt <= mt_pos;
      cap_st <= st_pos;
    end
  end

  ssi_clk_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sclk_in   (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  ssi_word_encoder #(
    .MT_BITS   (MT_BITS),
    .ST_BITS   (ST_BITS),
    .GRAY_CODE (GRAY_CODE)
  ) u_enc (
    .mt_in (cap_mt),
    .st_in (cap_st),
    .inv   (msb_inv),
    .word  (enc_word)
  );

  ssi_frame_ctrl #(
    .WORD_BITS    (WORD_BITS),
    .IDLE_CYCLES  (IDLE_CYCLES),
    .LATCH_CYCLES (LATCH_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .enc_word   (enc_word),
    .state      (state),
    .frame_word (frame_word),
    .sdata      (sdata),
    .strobe     (strobe)
  );
endmodule

// File: rtl/ssi_position_tx_chk.sv
module ssi_position_tx_chk
  import ssi_tx_pkg::*;
#(
  parameter int WORD_BITS = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input ssi_state_e           state,
  input logic                 sclk_fall,
  input logic                 strobe,
  input logic [WORD_BITS-1:0] frame_word
);
  // R1: a frame is entered only from the locked idle state on a falling edge
  a_r1_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && $past(state) != ST_SHIFT) |->
      ($past(state) == ST_IDLE && $past(sclk_fall)));

  // R4: the strobe drops only when a frame has ended or been abandoned
  a_r4_strobe_drops_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> ($past(state) == ST_SHIFT || $past(state) == ST_GAP));

  // R6: a falling edge inside the gap keeps the block in the gap
  a_r6_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP && sclk_fall) |=> (state == ST_GAP));

  // R7: leaving a frame goes either to the gap or, on timeout, to the latch window
  a_r7_shift_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_SHIFT && state != ST_SHIFT) |->
      (state == ST_GAP || state == ST_LATCH));

  // R8: the outgoing word never changes while the strobe stays high
  a_r8_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> $stable(frame_word));
endmodule

bind ssi_position_tx ssi_position_tx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .state      (state),
  .sclk_fall  (sclk_fall),
  .strobe     (strobe),
  .frame_word (frame_word)
);

// File: tb/tb_ssi_position_tx.sv
`timescale 1ps/1ps
module tb_ssi_position_tx;
  localparam int CLK_PERIOD_PS = 62500;
  localparam int IDLE_CYC      = 640;
  localparam int LATCH_CYC     = 560;
  localparam int NBITS         = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] b_mt = '0;
  logic [11:0] b_st = '0;
  logic        b_val = 1'b0;
  logic        b_inv = 1'b0;
  logic        sclk = 1'b1;
  logic        sd_b, sd_g, stb_b, stb_g;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit in_frame = 1'b0;
  bit run_cmp = 1'b0;

  // Bench view of the word that the next latch window should have captured.
  logic [13:0] lat_mt = '0;
  logic [11:0] lat_st = '0;
  bit          lat_inv = 1'b0;

  always #(CLK_PERIOD_PS/2) clk = ~clk;

  ssi_position_tx #(.MT_BITS(12), .ST_BITS(12), .GRAY_CODE(0),
                    .IDLE_CYCLES(IDLE_CYC), .LATCH_CYCLES(LATCH_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .mt_pos(b_mt[11:0]), .st_pos(b_st),
    .pos_valid(b_val), .sclk(sclk), .msb_inv(b_inv), .sdata(sd_b), .strobe(stb_b));

  ssi_position_tx #(.MT_BITS(14), .ST_BITS(10), .GRAY_CODE(1),
                    .IDLE_CYCLES(IDLE_CYC), .LATCH_CYCLES(LATCH_CYC)) dut_gray (
    .clk(clk), .rst_n(rst_n), .mt_pos(b_mt), .st_pos(b_st[9:0]),
    .pos_valid(b_val), .sclk(sclk), .msb_inv(b_inv), .sdata(sd_g), .strobe(stb_g));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_word(input logic [13:0] m_in, input logic [11:0] s_in,
                                           input int mb, input int sb, input bit inv,
                                           input bit gray);
    int m, s;
    m = int'(m_in) & ((1 << mb) - 1);
    s = int'(s_in) & ((1 << sb) - 1);
    if (inv) m = m ^ (1 << (mb - 1));
    if (gray) begin
      m = m ^ (m >> 1);
      s = s ^ (s >> 1);
    end
    return 24'((m << sb) | s);
  endfunction

  // Every clock: strobe high inside a frame, both instances share timing (R4).
  always @(negedge clk) begin
    if (run_cmp) begin
      if (in_frame) chk(stb_b == 1'b1, "R4", "strobe inside frame", stb_b, 1);
      chk(stb_b == stb_g, "R4", "strobe timing of both builds", stb_g, stb_b);
    end
  end

  task automatic run_frame(input int half, input int nfalls, input bit gap_mode,
                           input string tag, input logic [13:0] nm, input logic [11:0] ns,
                           input bit ninv, input bit nval);
    logic [23:0] wb, wg;
    bit eb, eg;
    wb = ref_word(lat_mt, lat_st, 12, 12, lat_inv, 1'b0);
    wg = ref_word(lat_mt, lat_st, 14, 10, lat_inv, 1'b1);
    chk(sd_b == !gap_mode, gap_mode ? "R6" : "R5", "line before first edge", sd_b, !gap_mode);
    in_frame = 1'b1;
    for (int i = 0; i < nfalls; i++) begin
      if (i >= 1) begin
        eb = gap_mode ? 1'b0 : wb[NBITS - i];
        eg = gap_mode ? 1'b0 : wg[NBITS - i];
        chk(sd_b == eb, gap_mode ? "R6" : tag, $sformatf("binary bit %0d", i - 1), sd_b, eb);
        chk(sd_g == eg, gap_mode ? "R6" : "R3", $sformatf("gray bit %0d", i - 1), sd_g, eg);
      end
      if (i == 2) begin
        b_mt = nm; b_st = ns; b_inv = ninv; b_val = nval;
      end
      sclk = 1'b0;
      repeat (half) @(negedge clk);
      sclk = 1'b1;
      repeat (half) @(negedge clk);
    end
    in_frame = 1'b0;
    if (nfalls == NBITS + 1) begin
      chk(sd_b == 1'b0 && sd_g == 1'b0, "R5", "line low after last bit", sd_b, 0);
      chk(stb_b == 1'b1, "R5", "strobe high in gap", stb_b, 1);
    end
  endtask

  // Quiet time until the latch window, then its length; then update the bench word.
  task automatic settle(input int elapsed, input string tag);
    int quiet, low;
    quiet = elapsed;
    while (stb_b == 1'b1 && quiet < 3000) begin
      @(negedge clk);
      quiet++;
    end
    chk(quiet >= IDLE_CYC && quiet <= IDLE_CYC + 5, tag, "quiet cycles to latch", quiet, IDLE_CYC + 3);
    chk(sd_b == 1'b0, "R5", "line low in latch window", sd_b, 0);
    low = 0;
    while (stb_b == 1'b0 && low < 3000) begin
      @(negedge clk);
      low++;
    end
    chk(low >= LATCH_CYC - 1 && low <= LATCH_CYC + 1, "R4", "latch window length", low, LATCH_CYC);
    chk(sd_b == 1'b1 && sd_g == 1'b1, "R5", "line high when locked", sd_b, 1);
    if (b_val) begin
      lat_mt = b_mt;
      lat_st = b_st;
    end
    lat_inv = b_inv;
  endtask

  initial begin
    int low;
    repeat (4) @(negedge clk);
    chk(stb_b == 1'b0 && stb_g == 1'b0, "R9", "strobe in reset", stb_b, 0);
    chk(sd_b == 1'b0 && sd_g == 1'b0, "R9", "data in reset", sd_b, 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    low = 0;
    while (stb_b == 1'b0 && low < 3000) begin
      @(negedge clk);
      low++;
    end
    chk(low >= LATCH_CYC && low <= LATCH_CYC + 4, "R4", "latch window after reset", low, LATCH_CYC + 2);
    chk(sd_b == 1'b1, "R5", "line high when locked", sd_b, 1);

    // Zero word after reset with no valid input, slow reader.
    run_frame(16, NBITS + 1, 1'b0, "R9", 14'h2A5C, 12'hB37, 1'b0, 1'b1);
    settle(16, "R4");
    // Fast reader; new inputs mid-frame must not disturb it.
    run_frame(2, NBITS + 1, 1'b0, "R8", 14'h1234, 12'hFED, 1'b1, 1'b1);
    settle(2, "R4");
    // Inverted top bit, slow reader; valid withdrawn for next window.
    run_frame(16, NBITS + 1, 1'b0, "R2", 14'h0F0F, 12'h5A5, 1'b0, 1'b0);
    settle(16, "R4");
    // Previous position repeated, inversion now off.
    run_frame(2, NBITS + 1, 1'b0, "R8", 14'h0F0F, 12'h5A5, 1'b0, 1'b1);
    repeat (300) @(negedge clk);
    chk(sd_b == 1'b0 && stb_b == 1'b1, "R6", "short gap state", sd_b, 0);
    run_frame(2, 5, 1'b1, "R6", 14'h0F0F, 12'h5A5, 1'b0, 1'b1);
    chk(stb_b == 1'b1, "R6", "strobe high after short gap burst", stb_b, 1);
    settle(2, "R6");
    run_frame(2, NBITS + 1, 1'b0, "R1", 14'h3C01, 12'h801, 1'b1, 1'b1);
    settle(2, "R4");
    // Abandoned frame after seven bits.
    run_frame(2, 8, 1'b0, "R7", 14'h0155, 12'h2AA, 1'b0, 1'b1);
    settle(2, "R7");
    run_frame(2, NBITS + 1, 1'b0, "R7", 14'h3FFF, 12'hFFF, 1'b1, 1'b1);
    settle(2, "R4");
    for (int k = 0; k < 4; k++) begin
      run_frame((k % 2 == 0) ? 16 : 2, NBITS + 1, 1'b0, "R1",
                14'($urandom), 12'($urandom), 1'($urandom), 1'b1);
      settle((k % 2 == 0) ? 16 : 2, "R4");
    end
    run_frame(2, NBITS + 1, 1'b0, "R1", 14'h0000, 12'h000, 1'b0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule